// File: doc/BRIEF.md
# Streaming WEP Cipher Engine

This block sits inline between a frame FIFO and the radio interface and applies WEP protection to one frame at a time, a byte per cycle. Before each frame, software-side logic writes a per-frame seed: three initialisation-vector bytes followed by either five or thirteen secret key bytes. The seed is 8 bytes long for the 64-bit key size and 16 bytes long for the 128-bit key size. A frame-start strobe loads the seed into an RC4 state and runs key scheduling. The data stream is then XORed with the RC4 keystream.

In the encrypt direction the engine forms a CRC-32 over the plaintext. When the input marks its last byte, the engine appends the four-byte integrity value and encrypts it with the continuing keystream. In the decrypt direction every decrypted byte, including the trailing four integrity bytes, is passed on. At the end of the frame the running CRC is checked, and a one-cycle error pulse flags a mismatch.

Both directions use the same keystream hardware. The stream is never stalled by the cipher once scheduling is done, so no frame buffer is needed.

Top module: `wep_stream_engine`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `icv_err` are all low.
- R2: A write with `seed_we` high stores `seed_data` at byte `seed_idx` of the seed. Bytes 0 to 2 hold the IV and bytes 3 up are the secret key. `long_key` is sampled with `frame_start`: a value of 1 selects a 16-byte seed and a value of 0 selects an 8-byte seed. Seed writes made while a frame is in progress are ignored.
- R3: When `frame_start` is accepted from idle, key scheduling runs for 256 cycles. During these cycles `in_ready` is low, and it can rise in the 257th cycle after the start edge.
- R4: The keystream is standard RC4. The state is initialised to the identity and scheduled with `j += S[i] + seed[i mod len]` and a swap. Each generated byte increments `i`, adds `S[i]` to `j`, swaps the two entries and outputs `S[S[i]+S[j]]`. Exactly one keystream byte is used per output byte, and each output byte is the input byte XOR the keystream byte.
- R5: In the encrypt direction (`dir_tx`=1 at frame start), the CRC-32 is computed over the plaintext bytes. It uses the reflected polynomial 0xEDB88320, a preset of all ones and a final inversion. After the input byte marked `in_last`, the four CRC bytes follow least-significant first, encrypted. `out_last` is set only on the fourth CRC byte.
- R6: In the decrypt direction, every decrypted byte is output, and `out_last` follows `in_last`. If the CRC over the decrypted payload disagrees with the final four decrypted bytes, read least-significant first, `icv_err` pulses for one cycle. The pulse occurs in the cycle in which the last byte becomes valid at the output.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. No byte is lost or duplicated under any backpressure pattern.
- R8: `frame_start` has no effect while a frame is in progress.
- R9: Both seed lengths produce the correct stream in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_we | input | 1 | Seed byte write strobe |
| seed_idx | input | 4 | Seed byte index |
| seed_data | input | 8 | Seed byte value |
| long_key | input | 1 | 1: 16-byte seed, 0: 8-byte seed (sampled at frame start) |
| dir_tx | input | 1 | 1: encrypt and append ICV, 0: decrypt and check (sampled at frame start) |
| frame_start | input | 1 | Begin a frame; starts key scheduling |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks last input byte of the frame |
| in_ready | output | 1 | Engine accepts an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks last output byte of the frame |
| out_ready | input | 1 | Downstream accepts the output byte |
| icv_err | output | 1 | One-cycle pulse on a decrypt integrity mismatch |

## Verification
The properties assume that the downstream side honours the valid/ready rule. They also assume that `frame_start` pulses during a frame are legal and must simply be dropped. The bench drives every input one time unit after the rising edge and samples at the falling edge, so `out_ready` is steady across each handshake edge. The bench raises `frame_start` and writes a seed byte in the middle of a frame, and applies pseudo-random backpressure on `out_ready`, so that the holding and ignore properties are exercised rather than vacuous. Decrypt frames are built from properly encrypted payloads, and a corrupted byte is injected only when an error pulse is expected.

// File: rtl/wep_pkg.sv
// Shared constants, types and the CRC-32 byte step for the WEP engine.
// Assumes the reflected CRC-32 form (LSB first) with an all-ones preset.
package wep_pkg;

    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
    // Register value left after running the CRC over data plus its own ICV
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_ICV
    } eng_state_t;

    // Advance a reflected CRC-32 register by one byte
    function automatic logic [31:0] crc32_step(input logic [31:0] crc,
                                               input logic [7:0]  data);
        logic [31:0] r;
        r = crc ^ {24'd0, data};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/wep_crc32.sv
// Running CRC-32 register. Cleared to the preset on `clear`, advanced by one
// byte whenever `en` is high. `crc_nxt` shows the value after the current byte.
// Assumes clear and en are never high in the same cycle.
module wep_crc32
    import wep_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc,
    output logic [31:0] crc_nxt
);

    logic [31:0] crc_q;

    // Combinational one-byte advance
    always_comb crc_nxt = crc32_step(crc_q, data);

    // CRC register update
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_PRESET;
        else if (clear)  crc_q <= CRC_PRESET;
        else if (en)     crc_q <= crc_nxt;
    end

    assign crc = crc_q;

endmodule

// File: rtl/wep_rc4_core.sv
// RC4 keystream generator. On `start` the state array is set to the identity
// and 256 scheduling cycles mix in the seed. After that `ready` is high and
// `ks_byte` shows the next keystream byte, and `step` consumes it.
// Assumes the seed is held constant from start until ready.
module wep_rc4_core #(
    parameter int SEED_MAX = 16,
    parameter int SEED_MIN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  long_seed,
    input  logic [SEED_MAX*8-1:0] seed_flat,
    input  logic                  step,
    output logic                  ready,
    output logic [7:0]            ks_byte
);

    localparam int          N_STATE  = 256;
    localparam logic [7:0]  I_FINAL  = 8'(N_STATE - 1);

    logic [7:0] sbox [N_STATE];
    logic [7:0] i_q, j_q;
    logic       sched_q, ready_q;

    logic [7:0] sidx, seed_byte, ksa_j;
    logic [7:0] i_n, j_n, si, sj, t_idx;

    // Seed byte selection for scheduling: index wraps at the seed length
    always_comb begin
        sidx      = long_seed ? 8'(int'(i_q) % SEED_MAX) : 8'(int'(i_q) % SEED_MIN);
        seed_byte = seed_flat[int'(sidx)*8 +: 8];
        ksa_j     = j_q + sbox[i_q] + seed_byte;
    end

    // Generation step: next indices, swap values and post-swap output lookup
    always_comb begin
        i_n   = i_q + 8'd1;
        si    = sbox[i_n];
        j_n   = j_q + si;
        sj    = sbox[j_n];
        t_idx = si + sj;
        if (t_idx == i_n)      ks_byte = sj;
        else if (t_idx == j_n) ks_byte = si;
        else                   ks_byte = sbox[t_idx];
    end

    // Control registers: phase flags and the two indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sched_q <= 1'b0;
            ready_q <= 1'b0;
            i_q     <= 8'd0;
            j_q     <= 8'd0;
        end else if (start) begin
            sched_q <= 1'b1;
            ready_q <= 1'b0;
            i_q     <= 8'd0;
            j_q     <= 8'd0;
        end else if (sched_q) begin
            if (i_q == I_FINAL) begin
                sched_q <= 1'b0;
                ready_q <= 1'b1;
                i_q     <= 8'd0;
                j_q     <= 8'd0;
            end else begin
                i_q <= i_q + 8'd1;
                j_q <= ksa_j;
            end
        end else if (ready_q && step) begin
            i_q <= i_n;
            j_q <= j_n;
        end
    end

    // State array: identity fill, scheduling swaps, generation swaps (no reset: datapath)
    always_ff @(posedge clk) begin
        if (start) begin
            for (int k = 0; k < N_STATE; k++) sbox[k] <= 8'(k);
        end else if (sched_q) begin
            sbox[i_q]   <= sbox[ksa_j];
            sbox[ksa_j] <= sbox[i_q];
        end else if (ready_q && step) begin
            sbox[i_n] <= sj;
            sbox[j_n] <= si;
        end
    end

    assign ready = ready_q;

endmodule

// File: rtl/wep_stream_engine.sv
// Inline WEP engine: seed store, frame sequencing, stream XOR, ICV append on
// encrypt and ICV check on decrypt. One byte per cycle once scheduling ends.
// Assumes the input is a single frame at a time, terminated by in_last.
module wep_stream_engine
    import wep_pkg::*;
#(
    parameter int SEED_LONG  = 16,
    parameter int SEED_SHORT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         seed_we,
    input  logic [$clog2(SEED_LONG)-1:0] seed_idx,
    input  logic [7:0]                   seed_data,
    input  logic                         long_key,
    input  logic                         dir_tx,
    input  logic                         frame_start,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    output logic                         in_ready,
    output logic                         out_valid,
    output logic [7:0]                   out_data,
    output logic                         out_last,
    input  logic                         out_ready,
    output logic                         icv_err
);

    localparam int                 ICV_BYTES = 4;
    localparam int                 CW        = $clog2(ICV_BYTES);
    localparam logic [CW-1:0]      ICV_LAST  = CW'(ICV_BYTES - 1);

    eng_state_t                 state_q;
    logic                       tx_q, long_q;
    logic [7:0]                 seed_q [SEED_LONG];
    logic [SEED_LONG*8-1:0]     seed_flat;
    logic [31:0]                icv_q;
    logic [CW-1:0]              icv_cnt;
    logic                       out_valid_q, out_last_q, icv_err_q;
    logic [7:0]                 out_data_q;

    logic       ks_ready, ks_step, start_ok, slot_free, accept, icv_emit;
    logic [7:0] ks_byte, plain;
    logic [31:0] crc_cur, crc_nxt;

    // Flatten the seed store for the keystream core
    for (genvar g = 0; g < SEED_LONG; g++) begin : g_seed_flat
        assign seed_flat[g*8 +: 8] = seed_q[g];
    end

    // Handshake and datapath decode
    always_comb begin
        start_ok  = frame_start && (state_q == ST_IDLE);
        slot_free = !out_valid_q || out_ready;
        in_ready  = (state_q == ST_DATA) && ks_ready && slot_free;
        accept    = in_valid && in_ready;
        icv_emit  = (state_q == ST_ICV) && slot_free;
        ks_step   = accept || icv_emit;
        plain     = tx_q ? in_data : (in_data ^ ks_byte);
    end

    wep_rc4_core #(
        .SEED_MAX (SEED_LONG),
        .SEED_MIN (SEED_SHORT)
    ) u_rc4 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .long_seed (long_q),
        .seed_flat (seed_flat),
        .step      (ks_step),
        .ready     (ks_ready),
        .ks_byte   (ks_byte)
    );

    wep_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_ok),
        .en      (accept),
        .data    (plain),
        .crc     (crc_cur),
        .crc_nxt (crc_nxt)
    );

    // Seed store: writable only between frames (no reset: content is loaded before use)
    always_ff @(posedge clk) begin
        if (seed_we && (state_q == ST_IDLE)) seed_q[seed_idx] <= seed_data;
    end

    // Frame sequencer: idle -> data -> (encrypt only) ICV append -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tx_q    <= 1'b0;
            long_q  <= 1'b0;
            icv_q   <= 32'd0;
            icv_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_ok) begin
                    state_q <= ST_DATA;
                    tx_q    <= dir_tx;
                    long_q  <= long_key;
                end
                ST_DATA: if (accept && in_last) begin
                    if (tx_q) begin
                        icv_q   <= ~crc_nxt;
                        icv_cnt <= '0;
                        state_q <= ST_ICV;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_ICV: if (icv_emit) begin
                    icv_q   <= icv_q >> 8;
                    icv_cnt <= icv_cnt + 1'b1;
                    if (icv_cnt == ICV_LAST) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output register with valid/ready hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= 8'd0;
            out_last_q  <= 1'b0;
        end else if (accept) begin
            out_valid_q <= 1'b1;
            out_data_q  <= in_data ^ ks_byte;
            out_last_q  <= in_last && !tx_q;
        end else if (icv_emit) begin
            out_valid_q <= 1'b1;
            out_data_q  <= icv_q[7:0] ^ ks_byte;
            out_last_q  <= (icv_cnt == ICV_LAST);
        end else if (out_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    // Decrypt integrity check via the CRC residue at the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) icv_err_q <= 1'b0;
        else        icv_err_q <= accept && in_last && !tx_q && (crc_nxt != CRC_RESIDUE);
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_last  = out_last_q;
    assign icv_err   = icv_err_q;

endmodule

// File: rtl/wep_stream_checker.sv
// Protocol and sequencing properties for wep_stream_engine, bound to it.
// Assumes the downstream side follows the valid/ready handshake rule.
module wep_stream_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_last,
    input logic       icv_err,
    input logic       ks_ready,
    input logic       tx_q
);

    // R3: no input is taken while the keystream is not yet scheduled
    p_sched_blocks_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ks_ready |-> !in_ready);

    // R7: a stalled output byte is held unchanged
    p_hold_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R6: the integrity error is a single-cycle pulse
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        icv_err |=> !icv_err);

    // R6: the error pulse coincides with the last decrypted byte at the output
    p_err_with_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        icv_err |-> (out_valid && out_last && !tx_q));

endmodule

bind wep_stream_engine wep_stream_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .icv_err   (icv_err),
    .ks_ready  (ks_ready),
    .tx_q      (tx_q)
);

// File: tb/tb_wep_stream_engine.sv
// Scoreboard bench: the driver computes RC4 and CRC-32 from the requirements,
// queues the expected output bytes, and a monitor compares them as they appear.
module tb_wep_stream_engine;

    typedef struct {
        logic [7:0] d;
        logic       l;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seed_we = 1'b0;
    logic [3:0] seed_idx = '0;
    logic [7:0] seed_data = '0;
    logic       long_key = 1'b0, dir_tx = 1'b0, frame_start = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_last, icv_err;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    int   n_checks = 0, n_errors = 0, err_pulses = 0, cycles = 0;
    bit   bp_en = 1'b0;
    exp_t exp_q[$];
    logic [7:0] seed_m [16];
    logic [7:0] ks_m[$];

    always #5 clk = ~clk;

    wep_stream_engine dut (
        .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_idx(seed_idx),
        .seed_data(seed_data), .long_key(long_key), .dir_tx(dir_tx),
        .frame_start(frame_start), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .icv_err(icv_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Reference CRC-32 (R5): reflected 0xEDB88320, preset ones, no final inversion here
    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // Reference RC4 (R4): fills ks_m with n keystream bytes for a key of length len
    task automatic rc4_model(input logic [7:0] key[16], input int len, input int n);
        logic [7:0] s[256];
        logic [7:0] i, j, tmp;
        for (int k = 0; k < 256; k++) s[k] = 8'(k);
        j = 0;
        for (int k = 0; k < 256; k++) begin
            j = j + s[k] + key[k % len];
            tmp = s[k]; s[k] = s[j]; s[j] = tmp;
        end
        ks_m.delete();
        i = 0; j = 0;
        for (int k = 0; k < n; k++) begin
            i = i + 8'd1;
            j = j + s[i];
            tmp = s[i]; s[i] = s[j]; s[j] = tmp;
            ks_m.push_back(s[8'(s[i] + s[j])]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Downstream readiness, optionally throttled
    always @(posedge clk) begin
        #1;
        out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
    end

    // Monitor: compare each transferred output byte with the scoreboard head
    always @(negedge clk) begin
        if (rst_n) begin
            if (icv_err) err_pulses++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected output byte", {24'd0, out_data}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_data == e.d, e.tag, "output byte", {24'd0, out_data}, {24'd0, e.d});
                    chk(out_last == e.l, e.tag, "out_last", {31'd0, out_last}, {31'd0, e.l});
                end
            end
        end
    end

    // R2: write the full seed store through the port
    task automatic load_seed(input logic [7:0] base);
        for (int k = 0; k < 16; k++) begin
            seed_m[k] = 8'(base + 8'(k * 37));
            @(posedge clk); #1;
            seed_we = 1'b1; seed_idx = 4'(k); seed_data = seed_m[k];
        end
        @(posedge clk); #1;
        seed_we = 1'b0;
    endtask

    // Run one frame: build expectations, start, check scheduling length, stream bytes
    task automatic run_frame(input bit tx, input bit lng, input int n,
                             input bit corrupt, input int poke, input string tag);
        logic [7:0] pt[$], full[$], drv[$];
        logic [31:0] c;
        int ksa_cycles;
        bit acc;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++) begin
            pt.push_back(8'($urandom));
            c = crc_upd(c, pt[k]);
        end
        c = ~c;
        full = pt;
        for (int k = 0; k < 4; k++) full.push_back(c[8*k +: 8]);
        rc4_model(seed_m, lng ? 16 : 8, n + 4);
        if (tx) begin
            drv = pt;
            for (int k = 0; k < n + 4; k++)
                exp_q.push_back('{full[k] ^ ks_m[k], k == n + 3, tag});
        end else begin
            for (int k = 0; k < n + 4; k++) drv.push_back(full[k] ^ ks_m[k]);
            if (corrupt) drv[n / 2] = drv[n / 2] ^ 8'h5A;
            for (int k = 0; k < n + 4; k++)
                exp_q.push_back('{drv[k] ^ ks_m[k], k == n + 3, tag});
        end
        err_pulses = 0;
        @(posedge clk); #1;
        frame_start = 1'b1; dir_tx = tx; long_key = lng;
        @(posedge clk); #1;
        frame_start = 1'b0;
        ksa_cycles = 0;
        while (ksa_cycles < 1000) begin
            @(negedge clk);
            if (in_ready) break;
            ksa_cycles++;
        end
        chk(ksa_cycles == 256, "R3", "scheduling cycles with in_ready low", ksa_cycles, 256);
        @(posedge clk); #1;
        for (int k = 0; k < drv.size(); k++) begin
            in_valid = 1'b1; in_data = drv[k]; in_last = (k == drv.size() - 1);
            if (k == poke) begin
                // R8 and R2: start strobe and seed write during a frame must be ignored
                frame_start = 1'b1; dir_tx = ~tx; long_key = ~lng;
                seed_we = 1'b1; seed_idx = 4'd5; seed_data = ~seed_m[5];
            end
            do begin
                @(negedge clk); acc = in_ready;
                @(posedge clk); #1;
                frame_start = 1'b0; seed_we = 1'b0; dir_tx = tx; long_key = lng;
            end while (!acc);
        end
        in_valid = 1'b0; in_last = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(err_pulses == ((!tx && corrupt) ? 1 : 0), "R6", "icv_err pulses",
            err_pulses, (!tx && corrupt) ? 1 : 0);
    endtask

    initial begin
        logic [7:0] kv[16];
        logic [31:0] c;
        logic [7:0] ref_ks[10];
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", {31'd0, in_ready}, 0);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", {31'd0, out_valid}, 0);
        chk(icv_err == 1'b0, "R1", "icv_err in reset", {31'd0, icv_err}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R1", "idle after reset",
            {30'd0, in_ready, out_valid}, 0);

        // R4 and R5: sanity of the reference models against known answers
        kv[0] = 8'h4B; kv[1] = 8'h65; kv[2] = 8'h79;
        for (int k = 3; k < 16; k++) kv[k] = 8'h00;
        rc4_model(kv, 3, 10);
        ref_ks = '{8'hEB, 8'h9F, 8'h77, 8'h81, 8'hB7, 8'h34, 8'hCA, 8'h72, 8'hA7, 8'h19};
        for (int k = 0; k < 10; k++)
            chk(ks_m[k] == ref_ks[k], "R4", "model keystream", {24'd0, ks_m[k]}, {24'd0, ref_ks[k]});
        c = 32'hFFFFFFFF;
        for (int k = 0; k < 9; k++) c = crc_upd(c, 8'(8'h31 + k));
        chk(~c == 32'hCBF43926, "R5", "model CRC check value", ~c, 32'hCBF43926);

        // R5, R9: encrypt with the 8-byte seed, no backpressure
        load_seed(8'h11);
        run_frame(1'b1, 1'b0, 10, 1'b0, -1, "R5");
        // R7, R8, R9: encrypt with the 16-byte seed, backpressure, mid-frame poke
        load_seed(8'h5C);
        bp_en = 1'b1;
        run_frame(1'b1, 1'b1, 23, 1'b0, 7, "R8");
        // R2, R6: decrypt, seed untouched by the poke above, valid ICV
        run_frame(1'b0, 1'b1, 17, 1'b0, -1, "R2");
        // R6, R9: decrypt with the 8-byte seed, corrupted payload
        load_seed(8'hA3);
        run_frame(1'b0, 1'b0, 12, 1'b1, -1, "R6");
        // R4, R7: decrypt valid frame under backpressure, 8-byte seed
        run_frame(1'b0, 1'b0, 31, 1'b0, 3, "R4");
        bp_en = 1'b0;
        // R5: one-byte encrypt payload
        run_frame(1'b1, 1'b1, 1, 1'b0, -1, "R5");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule